// File: doc/BRIEF.md
# Power Button Event Controller

This block turns an active-low power button into power management events. The raw button level is synchronised and filtered on a millisecond time base. Only a level that has stayed put for roughly 15 ms is passed on. Each press (a high-to-low change of the filtered level) is classed by the power state the system has actually reached. In a sleep state the press is a wake event, and in the working state it is a sleep request. A press held far longer forces the system to soft-off.

The block holds a small status register and an enable register, reached over a simple select/write/read port. It drives an interrupt request, a one-cycle wake request, a one-cycle soft-off request and active-low power-on control outputs. The power state is supplied by the surrounding sequencer. It must reflect a state already entered, not one merely requested. The SCI enable level is also an input.

Top module: `pwrkey_evt_ctrl`

## Requirements
- R1: After reset, both registers read 0, `sci_irq`, `wake_req` and `soft_off_req` are 0, and `on_ctl_n` and `pwr_ctl_n` are 0 (power on).
- R2: The filtered button level follows the raw input only after the raw input has held one value for between 14 and 16 ticks of `TICK_CYC` clocks. A low pulse shorter than 14 ticks causes no event. A release (low-to-high change) causes no event.
- R3: A press while `pwr_state` is 1 to 5 (SL1 to SL5) is a wake event. It sets status bit 8, pulses `wake_req` for one cycle and drives `on_ctl_n` and both `pwr_ctl_n` bits to 0, whatever enable bit 8 holds.
- R4: A press while `pwr_state` is 0 (S0) sets status bit 8 and raises no `wake_req`.
- R5: `sci_irq` is 1 exactly while status bit 8 and enable bit 8 are both 1, lagging them by one cycle.
- R6: A press in S0 with `sci_en` at 0 drives `on_ctl_n` and both `pwr_ctl_n` bits to 1, whatever enable bit 8 holds. With `sci_en` at 1 the power outputs are unchanged.
- R7: When the filtered level has stayed low for 4000 ticks, `on_ctl_n` and both `pwr_ctl_n` bits go to 1 and `soft_off_req` pulses for one cycle. This happens once per press.
- R8: The override event clears status bit 8 and sets status bit 11.
- R9: Register select 0 is status and select 1 is enable. A write to status clears each of bits 8 and 11 where the written data has a 1, and a set event in the same cycle wins. A write to enable stores bit 8. `reg_rdata` shows the selected register one cycle after `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_n_raw | input | 1 | Raw power button, low when pressed |
| pwr_state | input | 3 | Power state reached: 0 = S0, 1..5 = SL1..SL5 |
| sci_en | input | 1 | SCI enable level |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register, registered |
| sci_irq | output | 1 | SCI interrupt request |
| wake_req | output | 1 | One-cycle wake request |
| soft_off_req | output | 1 | One-cycle soft-off (override) request |
| on_ctl_n | output | 1 | Power-on control, active low |
| pwr_ctl_n | output | 2 | Power control pair, active low |

## Verification
A stuck or mis-seeded debounce counter shows at the ports first. The status bit then sets earlier than 14 ticks or later than 16 ticks after a press, or it sets on a short glitch, so a read in that window exposes it within about 16 ms of stimulus. A wrong classification shows within a cycle or two after the filtered edge. It appears as a missing or spurious `wake_req` pulse, or as power outputs that went the wrong way. A wrong override counter shows near the 4000-tick boundary. A read taken just before that point must still find status bit 8 set and power on, and a read just after must find bit 11 set, power off and `sci_irq` low.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;
  localparam int REG_W        = 16;
  localparam int STAT_PB_BIT  = 8;
  localparam int STAT_OVR_BIT = 11;
  localparam int EN_PB_BIT    = 8;

  typedef enum logic [2:0] {
    PS_S0  = 3'd0,
    PS_SL1 = 3'd1,
    PS_SL2 = 3'd2,
    PS_SL3 = 3'd3,
    PS_SL4 = 3'd4,
    PS_SL5 = 3'd5
  } pwr_state_e;

  function automatic logic is_sleeping(input logic [2:0] st);
    return (st >= 3'(PS_SL1)) && (st <= 3'(PS_SL5));
  endfunction
endpackage

// File: rtl/pwrkey_tick.sv
module pwrkey_tick #(
  parameter int TICK_CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (cnt == CW'(TICK_CYC - 1)) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwrkey_debounce.sv
module pwrkey_debounce #(
  parameter int DB_TICKS    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic raw_n,
  output logic db_lvl,
  output logic db_fall
);
  localparam int DCW = $clog2(DB_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_s;
  logic [DCW-1:0]         cnt;
  logic                   key_s;

  assign key_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      prev_s  <= 1'b1;
      db_lvl  <= 1'b1;
      db_fall <= 1'b0;
      cnt     <= '0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_n};
      prev_s  <= key_s;
      db_fall <= 1'b0;
      // any transition, or agreement with the held level, restarts the window
      if ((key_s != prev_s) || (key_s == db_lvl)) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == DCW'(DB_TICKS - 1)) begin
          db_lvl  <= key_s;
          db_fall <= ~key_s;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwrkey_hold.sv
module pwrkey_hold #(
  parameter int OVR_TICKS = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic db_lvl,
  output logic ovr_fire
);
  localparam int HCW = $clog2(OVR_TICKS + 1);

  logic [HCW-1:0] cnt;
  logic           done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      done     <= 1'b0;
      ovr_fire <= 1'b0;
    end else begin
      ovr_fire <= 1'b0;
      if (db_lvl) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (tick && !done) begin
        if (cnt == HCW'(OVR_TICKS - 1)) begin
          ovr_fire <= 1'b1;
          done     <= 1'b1;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwrkey_evt_ctrl.sv
module pwrkey_evt_ctrl
  import pwrkey_pkg::*;
#(
  parameter int TICK_CYC  = 250000,
  parameter int DB_TICKS  = 15,
  parameter int OVR_TICKS = 4000,
  parameter int PCTL_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_n_raw,
  input  logic [2:0]        pwr_state,
  input  logic              sci_en,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              sci_irq,
  output logic              wake_req,
  output logic              soft_off_req,
  output logic              on_ctl_n,
  output logic [PCTL_W-1:0] pwr_ctl_n
);
  logic tick, db_lvl, db_fall, ovr_fire;
  logic stat_pb, stat_ovr, en_pb;
  logic pb_nx, ovr_nx, off_nx, sleeping;
  logic [REG_W-1:0] stat_word, en_word;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign sleeping     = is_sleeping(pwr_state);

  pwrkey_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  pwrkey_debounce #(.DB_TICKS(DB_TICKS), .SYNC_STAGES(2)) u_deb (
    .clk(clk), .rst(rst), .tick(tick), .raw_n(key_n_raw),
    .db_lvl(db_lvl), .db_fall(db_fall)
  );

  pwrkey_hold #(.OVR_TICKS(OVR_TICKS)) u_hold (
    .clk(clk), .rst(rst), .tick(tick), .db_lvl(db_lvl), .ovr_fire(ovr_fire)
  );

  always_comb begin
    pb_nx  = stat_pb;
    ovr_nx = stat_ovr;
    off_nx = on_ctl_n;
    if (reg_wr && !reg_sel) begin
      if (reg_wdata[STAT_PB_BIT])  pb_nx  = 1'b0;
      if (reg_wdata[STAT_OVR_BIT]) ovr_nx = 1'b0;
    end
    if (db_fall) begin
      pb_nx = 1'b1;
      if (sleeping)     off_nx = 1'b0;
      else if (!sci_en) off_nx = 1'b1;
    end
    if (ovr_fire) begin
      pb_nx  = 1'b0;
      ovr_nx = 1'b1;
      off_nx = 1'b1;
    end
  end

  always_comb begin
    stat_word               = '0;
    stat_word[STAT_PB_BIT]  = stat_pb;
    stat_word[STAT_OVR_BIT] = stat_ovr;
    en_word                 = '0;
    en_word[EN_PB_BIT]      = en_pb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_pb      <= 1'b0;
      stat_ovr     <= 1'b0;
      en_pb        <= 1'b0;
      on_ctl_n     <= 1'b0;
      pwr_ctl_n    <= '0;
      sci_irq      <= 1'b0;
      wake_req     <= 1'b0;
      soft_off_req <= 1'b0;
      reg_rdata    <= '0;
    end else begin
      stat_pb      <= pb_nx;
      stat_ovr     <= ovr_nx;
      on_ctl_n     <= off_nx;
      pwr_ctl_n    <= {PCTL_W{off_nx}};
      wake_req     <= db_fall && sleeping;
      soft_off_req <= ovr_fire;
      sci_irq      <= stat_pb && en_pb;
      reg_rdata    <= reg_sel ? en_word : stat_word;
      if (reg_wr && reg_sel) en_pb <= reg_wdata[EN_PB_BIT];
    end
  end
endmodule

// File: rtl/pwrkey_evt_checker.sv
module pwrkey_evt_checker #(
  parameter int PCTL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        pwr_state,
  input logic              db_lvl,
  input logic              db_fall,
  input logic              ovr_fire,
  input logic              stat_pb,
  input logic              stat_ovr,
  input logic              en_pb,
  input logic              sci_irq,
  input logic              wake_req,
  input logic              soft_off_req,
  input logic              on_ctl_n,
  input logic [PCTL_W-1:0] pwr_ctl_n
);
  assert_fall_edge_R2: assert property (@(posedge clk) disable iff (rst)
    db_fall |-> (!db_lvl && $past(db_lvl)));

  assert_wake_power_R3: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (!on_ctl_n && pwr_ctl_n == '0 && stat_pb));

  assert_no_wake_s0_R4: assert property (@(posedge clk) disable iff (rst)
    (db_fall && pwr_state == 3'd0) |=> !wake_req);

  assert_sci_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(en_pb) |-> !sci_irq);

  assert_fire_while_low_R7: assert property (@(posedge clk) disable iff (rst)
    ovr_fire |-> !db_lvl);

  assert_override_off_R7: assert property (@(posedge clk) disable iff (rst)
    soft_off_req |-> (on_ctl_n && pwr_ctl_n == '1));

  assert_override_status_R8: assert property (@(posedge clk) disable iff (rst)
    soft_off_req |-> (stat_ovr && !stat_pb));
endmodule

bind pwrkey_evt_ctrl pwrkey_evt_checker #(.PCTL_W(PCTL_W)) u_chk (
  .clk(clk), .rst(rst), .pwr_state(pwr_state), .db_lvl(db_lvl),
  .db_fall(db_fall), .ovr_fire(ovr_fire), .stat_pb(stat_pb),
  .stat_ovr(stat_ovr), .en_pb(en_pb), .sci_irq(sci_irq),
  .wake_req(wake_req), .soft_off_req(soft_off_req),
  .on_ctl_n(on_ctl_n), .pwr_ctl_n(pwr_ctl_n)
);

// File: tb/pwrkey_evt_ctrl_bench.sv
`timescale 1ns/1ps
module pwrkey_evt_ctrl_bench;
  localparam int TICK = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_n_raw = 1'b1;
  logic [2:0]  pwr_state = 3'd0;
  logic        sci_en = 1'b1;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sci_irq, wake_req, soft_off_req, on_ctl_n;
  logic [1:0]  pwr_ctl_n;

  int n_chk = 0;
  int n_bad = 0;
  int wake_cnt = 0;
  int off_cnt = 0;

  always #2 clk = ~clk;

  pwrkey_evt_ctrl #(.TICK_CYC(TICK), .DB_TICKS(15), .OVR_TICKS(4000)) u_pwrkey_evt_ctrl (
    .clk(clk), .rst(rst), .key_n_raw(key_n_raw), .pwr_state(pwr_state),
    .sci_en(sci_en), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sci_irq(sci_irq), .wake_req(wake_req),
    .soft_off_req(soft_off_req), .on_ctl_n(on_ctl_n), .pwr_ctl_n(pwr_ctl_n)
  );

  always @(negedge clk) begin
    if (wake_req)     wake_cnt++;
    if (soft_off_req) off_cnt++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; key_n_raw = 1'b1; reg_wr = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    wake_cnt = 0; off_cnt = 0;
  endtask

  task automatic reg_write(input logic sel, input logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [15:0] d);
    reg_sel = sel;
    cyc(2);
    d = reg_rdata;
  endtask

  // {pwr_state[6:4], sci_en[3], en_bit8[2], exp_wake[1], exp_on_n[0]}
  localparam logic [6:0] VEC [7] = '{
    {3'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd3, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd5, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    do_reset();

    // R1: reset state
    reg_read(1'b0, rd); check("R1 status", rd, 16'h0000);
    reg_read(1'b1, rd); check("R1 enable", rd, 16'h0000);
    check("R1 outputs", {sci_irq, wake_req, soft_off_req, on_ctl_n, pwr_ctl_n}, '0);

    // R3 R4 R5 R6: table walk
    for (int i = 0; i < 7; i++) begin
      do_reset();
      pwr_state = VEC[i][6:4];
      sci_en    = VEC[i][3];
      reg_write(1'b1, {7'd0, VEC[i][2], 8'd0});
      key_n_raw = 1'b0; cyc(80);
      key_n_raw = 1'b1; cyc(80);
      reg_read(1'b0, rd);
      check("R3/R4 status bit8", rd, 16'h0100);
      check("R3/R4 wake count", wake_cnt, {31'd0, VEC[i][1]});
      check("R3/R6 on_ctl_n", on_ctl_n, VEC[i][0]);
      check("R3/R6 pwr_ctl_n", pwr_ctl_n, {2{VEC[i][0]}});
      check("R5 sci_irq", sci_irq, VEC[i][2]);
    end

    // R2: short glitch and release give no event
    do_reset();
    pwr_state = 3'd0; sci_en = 1'b1;
    key_n_raw = 1'b0; cyc(40);
    key_n_raw = 1'b1; cyc(100);
    reg_read(1'b0, rd); check("R2 glitch ignored", rd, 16'h0000);

    // R2: window boundary, not yet at 13 ticks, done by 19
    key_n_raw = 1'b0; cyc(50);
    reg_read(1'b0, rd); check("R2 before window", rd, 16'h0000);
    cyc(24);
    reg_read(1'b0, rd); check("R2 after window", rd, 16'h0100);
    // R9: write-1-to-clear, release makes no new event
    reg_write(1'b0, 16'h0100);
    key_n_raw = 1'b1; cyc(100);
    reg_read(1'b0, rd); check("R9 w1c and R2 release", rd, 16'h0000);

    // R5 R9: clearing status drops sci
    reg_write(1'b1, 16'hFFFF);
    reg_read(1'b1, rd); check("R9 enable readback", rd, 16'h0100);
    key_n_raw = 1'b0; cyc(80); key_n_raw = 1'b1; cyc(80);
    check("R5 sci set", sci_irq, 1'b1);
    reg_write(1'b0, 16'h0800);
    cyc(3);
    check("R9 other bit no clear", sci_irq, 1'b1);
    reg_write(1'b0, 16'h0100);
    cyc(3);
    check("R5 sci dropped", sci_irq, 1'b0);

    // R7 R8: override, sci_en=1 and enable on
    key_n_raw = 1'b0; cyc(15900);
    check("R7 before limit on_ctl_n", on_ctl_n, 1'b0);
    reg_read(1'b0, rd); check("R8 before limit status", rd, 16'h0100);
    check("R5 sci before override", sci_irq, 1'b1);
    cyc(300);
    check("R7 after limit on_ctl_n", on_ctl_n, 1'b1);
    check("R7 after limit pwr_ctl_n", pwr_ctl_n, 2'b11);
    check("R7 one soft_off pulse", off_cnt, 1);
    reg_read(1'b0, rd); check("R8 status swap", rd, 16'h0800);
    cyc(3);
    check("R5 sci after override", sci_irq, 1'b0);
    key_n_raw = 1'b1; cyc(100);

    // R3: wake from SL5 restores power
    pwr_state = 3'd5; wake_cnt = 0;
    key_n_raw = 1'b0; cyc(80); key_n_raw = 1'b1; cyc(80);
    check("R3 SL5 wake pulse", wake_cnt, 1);
    check("R3 SL5 on_ctl_n", on_ctl_n, 1'b0);
    check("R3 SL5 pwr_ctl_n", pwr_ctl_n, 2'b00);
    reg_read(1'b0, rd); check("R3 SL5 status", rd, 16'h0900);
    reg_write(1'b0, 16'h0900);
    reg_read(1'b0, rd); check("R9 clear both", rd, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule